// File: doc/BRIEF.md
# Serial Bus Controller Event and Interrupt Status Unit

This unit collects the events reported by a serial bus engine and turns them into status, a single interrupt line and the index of the most urgent pending source. One-cycle event pulses (slave address match, stop seen, arbitration lost, not-acknowledge, repeated start) set sticky status bits. Two further status bits are live levels: transmit FIFO empty and bus busy. These bits follow their inputs and are never latched.

Software uses a small register port. It programs an enable mask at address 0. It clears sticky bits by writing ones to a clear register at address 1. It reads the combined status at address 2. The interrupt output is the registered OR of status AND enable. Alongside it, the unit reports the highest-numbered pending enabled bit, so that error sources such as arbitration loss and NACK are served before transmit empty.

Top module: `isr_unit`

## Requirements
- R1: After reset the sticky status bits and the enable register are 0, irqOut is 0 and pendIdx is 0.
- R2: An event pulse sets its sticky status bit at the next clock edge, and the bit stays set until it is cleared. The bit positions are: slave address match 6, stop 7, arbitration lost 8, NACK 10, repeated start 11.
- R3: A write to the clear register (address 1) clears each sticky bit whose data bit is 1. Zero data bits leave their status bits unchanged.
- R4: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 2 equals txFifoEmpty and status bit 9 equals busBusy at all times. A clear write has no effect on either bit.
- R6: A write to address 0 loads the enable register. Only bits 2, 6, 7, 8, 9, 10 and 11 are stored; all other bits read back as 0.
- R7: Reading address 0 returns the enable register and reading address 2 returns the status. Addresses 1 and 3 read 0, and a write to address 3 changes nothing.
- R8: irqOut is 1 in the cycle after status AND enable is nonzero, and 0 in the cycle after it is zero. This includes the cycle after an enable write.
- R9: When irqOut is 1, pendIdx holds the highest-numbered bit of status AND enable, registered in the same way as irqOut.
- R10: When status AND enable is zero, the following cycle shows irqOut 0 and pendIdx 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtSlaveAddr | input | 1 | Pulse: own slave address matched |
| evtStop | input | 1 | Pulse: stop condition seen |
| evtArbLost | input | 1 | Pulse: arbitration lost |
| evtNack | input | 1 | Pulse: not-acknowledge received |
| evtRepStart | input | 1 | Pulse: repeated start seen |
| txFifoEmpty | input | 1 | Level: transmit FIFO empty |
| busBusy | input | 1 | Level: bus currently busy |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 enable, 1 clear, 2 status, 3 spare) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| irqOut | output | 1 | Registered interrupt request |
| pendIdx | output | 4 | Highest pending enabled bit, 0 when none |

## Verification
The bench drives an event and a clear onto the same bit in the same cycle. A design that let the clear win would lose the event. It checks irqOut one cycle after an enable or clear write. A combinational interrupt would change a cycle early, and a slow one would keep reporting a source that is already cleared. Stacked pending sources are removed from the top down. A lowest-first or unmasked encoder would then report transmit empty or a disabled bit instead of NACK or arbitration loss. The bench also writes all ones to the clear register while busy and transmit empty are high, which catches a design that makes the live bits sticky.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int STAT_W = 16;
  localparam int IDX_W  = $clog2(STAT_W);
  localparam int ADDR_W = 2;

  localparam int B_TXE   = 2;
  localparam int B_SLV   = 6;
  localparam int B_STOP  = 7;
  localparam int B_ARB   = 8;
  localparam int B_BUSY  = 9;
  localparam int B_NACK  = 10;
  localparam int B_RSTRT = 11;

  localparam logic [STAT_W-1:0] STICKY_MASK =
    STAT_W'((1 << B_SLV) | (1 << B_STOP) | (1 << B_ARB) | (1 << B_NACK) | (1 << B_RSTRT));
  localparam logic [STAT_W-1:0] LEVEL_MASK = STAT_W'((1 << B_TXE) | (1 << B_BUSY));
  localparam logic [STAT_W-1:0] IMPL_MASK  = STICKY_MASK | LEVEL_MASK;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 2'd0,
    A_CLEAR  = 2'd1,
    A_STATUS = 2'd2,
    A_SPARE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              enWr;
    logic              clrWr;
    logic [STAT_W-1:0] wrBits;
    regSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWrData,
  output strobe_t           strobe
);
  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(regAddr);
    strobe.rdSel  = sel;
    strobe.wrBits = regWrData;
    strobe.enWr   = regWrEn && (sel == A_ENABLE);
    strobe.clrWr  = regWrEn && (sel == A_CLEAR);
  end
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [STAT_W-1:0] evtVec,
  input  logic [STAT_W-1:0] liveVec,
  output logic [STAT_W-1:0] rdData,
  output logic              irqOut,
  output logic [IDX_W-1:0]  pendIdx
);
  logic [STAT_W-1:0] stickyQ, enableQ, statusVec, masked, setVec, clrVec;
  logic [IDX_W-1:0]  topIdx;
  logic              irqQ;
  logic [IDX_W-1:0]  idxQ;

  assign setVec = evtVec & STICKY_MASK;
  assign clrVec = strobe.clrWr ? (strobe.wrBits & STICKY_MASK) : '0;

  // event set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enableQ <= '0;
    else if (strobe.enWr) enableQ <= strobe.wrBits & IMPL_MASK;
  end

  assign statusVec = stickyQ | (liveVec & LEVEL_MASK);
  assign masked    = statusVec & enableQ;

  // highest set bit wins
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < STAT_W; i++)
      if (masked[i]) topIdx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      idxQ <= '0;
    end else begin
      irqQ <= |masked;
      idxQ <= topIdx;
    end
  end

  assign irqOut  = irqQ;
  assign pendIdx = idxQ;

  always_comb begin
    case (strobe.rdSel)
      A_ENABLE: rdData = enableQ;
      A_STATUS: rdData = statusVec;
      default:  rdData = '0;
    endcase
  end

  generate
    for (genvar b = 0; b < STAT_W; b++) begin : g_chk
      if (STICKY_MASK[b]) begin : g_sticky
        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
          evtVec[b] |=> statusVec[b]);
        p_evt_beats_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
          (evtVec[b] && strobe.clrWr && strobe.wrBits[b]) |=> statusVec[b]);
        p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.clrWr && strobe.wrBits[b] && !evtVec[b]) |=> !statusVec[b]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
          (statusVec[b] && !(strobe.clrWr && strobe.wrBits[b])) |=> statusVec[b]);
      end
    end
  endgenerate

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(statusVec & enableQ)));
  p_idx_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (($past(masked) >> pendIdx) == STAT_W'(1)));
  p_none_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (pendIdx == '0));
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtSlaveAddr,
  input  logic              evtStop,
  input  logic              evtArbLost,
  input  logic              evtNack,
  input  logic              evtRepStart,
  input  logic              txFifoEmpty,
  input  logic              busBusy,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWrData,
  output logic [STAT_W-1:0] regRdData,
  output logic              irqOut,
  output logic [IDX_W-1:0]  pendIdx
);
  strobe_t           strobe;
  logic [STAT_W-1:0] evtVec, liveVec;

  always_comb begin
    evtVec          = '0;
    evtVec[B_SLV]   = evtSlaveAddr;
    evtVec[B_STOP]  = evtStop;
    evtVec[B_ARB]   = evtArbLost;
    evtVec[B_NACK]  = evtNack;
    evtVec[B_RSTRT] = evtRepStart;
    liveVec         = '0;
    liveVec[B_TXE]  = txFifoEmpty;
    liveVec[B_BUSY] = busBusy;
  end

  isr_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  isr_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .evtVec (evtVec),
    .liveVec(liveVec),
    .rdData (regRdData),
    .irqOut (irqOut),
    .pendIdx(pendIdx)
  );
endmodule

// File: tb/sim_isr_unit.sv
`timescale 1ns/1ps
module sim_isr_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic evtSlaveAddr = 0, evtStop = 0, evtArbLost = 0, evtNack = 0, evtRepStart = 0;
  logic txFifoEmpty = 0, busBusy = 0, regWrEn = 0;
  logic [1:0]  regAddr = 0;
  logic [15:0] regWrData = 0;
  logic [15:0] regRdData;
  logic        irqOut;
  logic [3:0]  pendIdx;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  isr_unit u0 (.*);

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic pulse(logic [15:0] m, logic [15:0] clr = 16'h0);
    evtSlaveAddr = m[6]; evtStop = m[7]; evtArbLost = m[8];
    evtNack = m[10]; evtRepStart = m[11];
    if (clr != 0) begin regWrEn = 1; regAddr = 2'd1; regWrData = clr; end
    @(negedge clk);
    {evtSlaveAddr, evtStop, evtArbLost, evtNack, evtRepStart} = '0;
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    regAddr = a; #0.1; d = regRdData;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd2, d); check("R1 status", d, 16'h0);
    rd(2'd0, d); check("R1 enable", d, 16'h0);
    check("R1 irq", 16'(irqOut), 16'h0);
    check("R1 idx", 16'(pendIdx), 16'h0);
  endtask

  task automatic t_set_clear();
    logic [15:0] d;
    pulse(16'h0DC0);
    rd(2'd2, d); check("R2 sticky set", d, 16'h0DC0);
    @(negedge clk); rd(2'd2, d); check("R2 sticky held", d, 16'h0DC0);
    check("R8 masked no irq", 16'(irqOut), 16'h0);
    wr(2'd1, 16'h0500);
    rd(2'd2, d); check("R3 partial clear", d, 16'h08C0);
    txFifoEmpty = 1; busBusy = 1;
    wr(2'd1, 16'hFFFF);
    rd(2'd2, d); check("R5 live bits survive clear", d, 16'h0204);
    txFifoEmpty = 0; busBusy = 0; #0.1;
    rd(2'd2, d); check("R5 live bits follow", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(16'h0400, 16'h0400);
    rd(2'd2, d); check("R4 event beats clear", d, 16'h0400);
    wr(2'd1, 16'h0400);
    rd(2'd2, d); check("R3 clear after collision", d, 16'h0);
  endtask

  task automatic t_enable_regs();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R6 enable implemented bits", d, 16'h0FC4);
    wr(2'd3, 16'h0000);
    rd(2'd0, d); check("R7 spare write ignored", d, 16'h0FC4);
    rd(2'd3, d); check("R7 spare reads 0", d, 16'h0);
    rd(2'd1, d); check("R7 clear reads 0", d, 16'h0);
  endtask

  task automatic t_priority();
    txFifoEmpty = 1;
    @(negedge clk);
    check("R9 txe irq", 16'(irqOut), 16'h1);
    check("R9 idx txe", 16'(pendIdx), 16'd2);
    pulse(16'h0400);
    check("R8 idx lags event", 16'(pendIdx), 16'd2);
    @(negedge clk); check("R9 nack over txe", 16'(pendIdx), 16'd10);
    pulse(16'h0100); @(negedge clk);
    check("R9 nack over arb", 16'(pendIdx), 16'd10);
    pulse(16'h0800); @(negedge clk);
    check("R9 repstart top", 16'(pendIdx), 16'd11);
    wr(2'd1, 16'h0800); @(negedge clk);
    check("R9 back to nack", 16'(pendIdx), 16'd10);
    wr(2'd1, 16'h0400); @(negedge clk);
    check("R9 arb next", 16'(pendIdx), 16'd8);
    wr(2'd1, 16'h0100); @(negedge clk);
    check("R9 txe last", 16'(pendIdx), 16'd2);
    txFifoEmpty = 0;
    @(negedge clk);
    check("R10 irq none", 16'(irqOut), 16'h0);
    check("R10 idx none", 16'(pendIdx), 16'h0);
  endtask

  task automatic t_irq_timing();
    wr(2'd0, 16'h0080);
    pulse(16'h0040);
    @(negedge clk);
    check("R8 disabled source no irq", 16'(irqOut), 16'h0);
    pulse(16'h0080);
    check("R8 irq one cycle later", 16'(irqOut), 16'h0);
    @(negedge clk);
    check("R8 irq raised", 16'(irqOut), 16'h1);
    check("R9 idx stop", 16'(pendIdx), 16'd7);
    wr(2'd0, 16'h0000);
    check("R8 irq held across enable write", 16'(irqOut), 16'h1);
    @(negedge clk);
    check("R8 irq dropped after disable", 16'(irqOut), 16'h0);
    check("R10 idx zero", 16'(pendIdx), 16'h0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_collision();
    t_enable_regs();
    wr(2'd1, 16'hFFFF);
    t_priority();
    wr(2'd1, 16'hFFFF);
    t_irq_timing();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule